// File: doc/BRIEF.md
# Host Port Outbound Word Path

This block carries 24-bit words from a processor core to an 8-bit external host. The core writes a word into a transmit holding register. The block then copies the word into a three-byte window that the host reads one byte at a time. Two flags control the handover. The core-side empty flag shows that the holding register can take a new word. The host-side full flag shows that the window holds a word the host has not finished reading. A word moves only when the holding register is loaded and the window has been drained. Only the host's read of the last byte frees the window for the next word.

The core polls the empty flag or takes an interrupt while it is set. The host polls its status byte or watches an active-low request pin. Both sides can also set two general-purpose flags that the other side reads in its status register. The host-to-core direction is not modelled: its flags read as permanently idle.

Top module: `hostport_tx_path`

## Requirements
- R1: Core status bit 1 (transmit empty) reads 1 whenever the holding register can accept a word.
- R2: A core write to the holding register makes core status bit 1 read 0 from the next clock.
- R3: On a clock edge where the window is not full and the holding register is loaded, the word moves into the window. After that edge, host status bit 0 (receive full) is 1 and core status bit 1 is 1.
- R4: A host read drives the window's high, middle and low bytes at byte addresses 5, 6 and 7.
- R5: A host read of address 7 while full clears receive full. A read of address 5 or 6 leaves it set.
- R6: `host_req_n` is low exactly when host control bit 0 (request enable) is 1 and receive full is set.
- R7: `core_irq` is high exactly when core control bit 1 (transmit interrupt enable) is 1 and transmit empty is 1. `core_irq_vector` is constant 0x32.
- R8: The host status byte at address 2 reads as follows: bit 0 receive full, bit 1 host-side transmit empty (always 1), bit 2 transmitter ready (always 1), bits 3-4 core control bits 3-4, bit 5 zero, bit 6 DMA status (0), bit 7 request asserted.
- R9: Core status reads as follows: bit 0 receive full of the other direction (0), bit 1 transmit empty, bit 2 command pending (0), bits 3-4 host control bits 3-4, all other bits 0. `core_ctrl_rd` returns the five stored core control bits. Host address 0 reads back host control bits 0, 1, 3 and 4 as written, and all other bits as 0. Unlisted host addresses read 0.
- R10: After reset, transmit empty is 1, receive full is 0, all control bits are 0, `host_req_n` is high and `core_irq` is low.
- R11: While the window is full, a newly written word stays in the holding register. The window keeps the old word until address 7 is read. The new word appears on the next edge after that read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_wr | input | 1 | Core write strobe for the holding register |
| core_wdata | input | 24 | Word written by the core |
| core_ctrl_wr | input | 1 | Core control register write strobe |
| core_ctrl_wdata | input | 5 | Core control bits (0 rx ie, 1 tx ie, 2 cmd ie, 3-4 flags) |
| core_ctrl_rd | output | 5 | Stored core control bits |
| core_status | output | 8 | Core status register |
| core_irq | output | 1 | Transmit-empty interrupt request |
| core_irq_vector | output | 8 | Fixed vector of the request |
| host_addr | input | 3 | Host byte address |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data for `host_addr` |
| host_req_n | output | 1 | Active-low data-waiting request to the host |

## Verification
The hardest case to set up is a second core write that lands while the window is still full, because two flags must be in a particular state at once. The host must have left the last byte unread, and the core must then reload the holding register. The directed part of the stimulus builds this on purpose. It writes one word, lets it transfer, writes another, and holds off the address-7 read for several cycles while reading the window. A random phase then mixes writes, partial reads and control updates, and a behavioural model is compared on every cycle.

// File: rtl/hp_pkg.sv
package hp_pkg;
   // core control bit positions
   localparam int CC_RXIE  = 0;
   localparam int CC_TXIE  = 1;
   localparam int CC_CMDIE = 2;
   localparam int CC_FLG0  = 3;
   localparam int CC_FLG1  = 4;
   localparam int CC_W     = 5;

   // host control bit positions
   localparam int HC_RREQ  = 0;
   localparam int HC_TREQ  = 1;
   localparam int HC_FLG0  = 3;
   localparam int HC_FLG1  = 4;

   // status bit positions
   localparam int HS_RXF   = 0;
   localparam int HS_TXE   = 1;
   localparam int HS_TRDY  = 2;
   localparam int HS_DMA   = 6;
   localparam int HS_REQ   = 7;
   localparam int CS_RDF   = 0;
   localparam int CS_TDE   = 1;
   localparam int CS_CMDP  = 2;
   localparam int CS_DMA   = 7;

   typedef struct packed {
      logic flg1;
      logic flg0;
      logic cmd_ie;
      logic tx_ie;
      logic rx_ie;
   } core_ctrl_t;

   typedef struct packed {
      logic flg1;
      logic flg0;
      logic tx_req;
      logic rx_req;
   } host_ctrl_t;
endpackage

// File: rtl/hp_tx_hold.sv
module hp_tx_hold #(
   parameter int WORD_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [WORD_W-1:0] wdata,
   input  logic              take,
   output logic              empty,
   output logic [WORD_W-1:0] word
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         empty <= 1'b1;
         word  <= '0;
      end else begin
         if (wr) begin
            word  <= wdata;
            empty <= 1'b0;
         end else if (take) begin
            empty <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/hp_rx_window.sv
module hp_rx_window #(
   parameter int WORD_W    = 24,
   parameter int BYTE_W    = 8,
   parameter int ADDR_W    = 3,
   parameter int BASE_ADDR = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [WORD_W-1:0] load_word,
   input  logic              rd,
   input  logic [ADDR_W-1:0] addr,
   output logic              full,
   output logic              hit,
   output logic [BYTE_W-1:0] byte_q
);
   localparam int NBYTES    = WORD_W / BYTE_W;
   localparam int LAST_ADDR = BASE_ADDR + NBYTES - 1;

   if (NBYTES * BYTE_W != WORD_W) begin : g_bad_width
      $error("word width must be a whole number of bytes");
   end
   if (LAST_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
      $error("byte window does not fit the host address space");
   end

   logic [WORD_W-1:0] win_q;
   logic [NBYTES-1:0] sel;
   logic [BYTE_W-1:0] lane [NBYTES];
   logic              last_rd;

   // byte k of the window, k = 0 being the most significant
   for (genvar k = 0; k < NBYTES; k++) begin : g_lane
      assign sel[k]  = (addr == ADDR_W'(BASE_ADDR + k));
      assign lane[k] = win_q[WORD_W-1-k*BYTE_W -: BYTE_W];
   end

   always_comb begin
      byte_q = '0;
      for (int k = 0; k < NBYTES; k++) begin
         if (sel[k]) byte_q = lane[k];
      end
   end

   assign hit     = |sel;
   assign last_rd = rd && (addr == ADDR_W'(LAST_ADDR));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full  <= 1'b0;
         win_q <= '0;
      end else if (load) begin
         full  <= 1'b1;
         win_q <= load_word;
      end else if (last_rd) begin
         full  <= 1'b0;
      end
   end
endmodule

// File: rtl/hp_ctrl_regs.sv
module hp_ctrl_regs
   import hp_pkg::*;
#(
   parameter int ADDR_W   = 3,
   parameter int BYTE_W   = 8,
   parameter int HCR_ADDR = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              core_wr,
   input  logic [CC_W-1:0]   core_wdata,
   input  logic              host_wr,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [BYTE_W-1:0] host_wdata,
   output core_ctrl_t        core_ctrl,
   output host_ctrl_t        host_ctrl
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         core_ctrl <= '0;
         host_ctrl <= '0;
      end else begin
         if (core_wr) core_ctrl <= core_ctrl_t'(core_wdata);
         if (host_wr && host_addr == ADDR_W'(HCR_ADDR)) begin
            host_ctrl.rx_req <= host_wdata[HC_RREQ];
            host_ctrl.tx_req <= host_wdata[HC_TREQ];
            host_ctrl.flg0   <= host_wdata[HC_FLG0];
            host_ctrl.flg1   <= host_wdata[HC_FLG1];
         end
      end
   end
endmodule

// File: rtl/hostport_tx_path.sv
module hostport_tx_path
   import hp_pkg::*;
#(
   parameter int WORD_W         = 24,
   parameter int BYTE_W         = 8,
   parameter int ADDR_W         = 3,
   parameter int HCR_ADDR       = 0,
   parameter int HSR_ADDR       = 2,
   parameter int WIN_BASE       = 5,
   parameter int VEC_W          = 8,
   parameter int TX_VECTOR      = 'h32,
   parameter bit REQ_ACTIVE_LOW = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              core_wr,
   input  logic [WORD_W-1:0] core_wdata,
   input  logic              core_ctrl_wr,
   input  logic [CC_W-1:0]   core_ctrl_wdata,
   output logic [CC_W-1:0]   core_ctrl_rd,
   output logic [7:0]        core_status,
   output logic              core_irq,
   output logic [VEC_W-1:0]  core_irq_vector,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic              host_rd,
   input  logic              host_wr,
   input  logic [BYTE_W-1:0] host_wdata,
   output logic [BYTE_W-1:0] host_rdata,
   output logic              host_req_n
);
   if (BYTE_W != 8) begin : g_bad_byte
      $error("host status layout needs an 8-bit byte");
   end
   if (TX_VECTOR >= (1 << VEC_W)) begin : g_bad_vec
      $error("vector does not fit its port");
   end

   logic              tx_empty;
   logic              rx_full;
   logic              xfer;
   logic              win_hit;
   logic [WORD_W-1:0] hold_word;
   logic [BYTE_W-1:0] win_byte;
   logic              req_on;
   logic [7:0]        host_stat;
   logic [7:0]        hcr_view;
   core_ctrl_t        cctl;
   host_ctrl_t        hctl;
   logic              unused_bits;

   // host-to-core direction is idle in this block
   localparam logic H2C_EMPTY = 1'b1;
   localparam logic C_RXF     = 1'b0;

   assign xfer = !rx_full && !tx_empty;

   hp_tx_hold #(.WORD_W(WORD_W)) i_hold (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (core_wr),
      .wdata (core_wdata),
      .take  (xfer),
      .empty (tx_empty),
      .word  (hold_word)
   );

   hp_rx_window #(
      .WORD_W    (WORD_W),
      .BYTE_W    (BYTE_W),
      .ADDR_W    (ADDR_W),
      .BASE_ADDR (WIN_BASE)
   ) i_win (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (xfer),
      .load_word (hold_word),
      .rd        (host_rd),
      .addr      (host_addr),
      .full      (rx_full),
      .hit       (win_hit),
      .byte_q    (win_byte)
   );

   hp_ctrl_regs #(
      .ADDR_W   (ADDR_W),
      .BYTE_W   (BYTE_W),
      .HCR_ADDR (HCR_ADDR)
   ) i_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .core_wr    (core_ctrl_wr),
      .core_wdata (core_ctrl_wdata),
      .host_wr    (host_wr),
      .host_addr  (host_addr),
      .host_wdata (host_wdata),
      .core_ctrl  (cctl),
      .host_ctrl  (hctl)
   );

   assign req_on = hctl.rx_req && rx_full;

   if (REQ_ACTIVE_LOW) begin : g_req_low
      assign host_req_n = !req_on;
   end else begin : g_req_high
      assign host_req_n = req_on;
   end

   assign core_irq        = cctl.tx_ie && tx_empty;
   assign core_irq_vector = VEC_W'(TX_VECTOR);
   assign core_ctrl_rd    = cctl;

   always_comb begin
      core_status          = '0;
      core_status[CS_RDF]  = C_RXF;
      core_status[CS_TDE]  = tx_empty;
      core_status[CS_CMDP] = 1'b0;
      core_status[CC_FLG0] = hctl.flg0;
      core_status[CC_FLG1] = hctl.flg1;
      core_status[CS_DMA]  = 1'b0;
   end

   always_comb begin
      host_stat          = '0;
      host_stat[HS_RXF]  = rx_full;
      host_stat[HS_TXE]  = H2C_EMPTY;
      host_stat[HS_TRDY] = H2C_EMPTY && !C_RXF;
      host_stat[CC_FLG0] = cctl.flg0;
      host_stat[CC_FLG1] = cctl.flg1;
      host_stat[HS_DMA]  = 1'b0;
      host_stat[HS_REQ]  = req_on;
   end

   always_comb begin
      hcr_view          = '0;
      hcr_view[HC_RREQ] = hctl.rx_req;
      hcr_view[HC_TREQ] = hctl.tx_req;
      hcr_view[HC_FLG0] = hctl.flg0;
      hcr_view[HC_FLG1] = hctl.flg1;
   end

   always_comb begin
      if (host_addr == ADDR_W'(HCR_ADDR))      host_rdata = hcr_view;
      else if (host_addr == ADDR_W'(HSR_ADDR)) host_rdata = host_stat;
      else if (win_hit)                        host_rdata = win_byte;
      else                                     host_rdata = '0;
   end

   assign unused_bits = ^{host_wdata[7:5], host_wdata[2]};
endmodule

// File: rtl/hostport_tx_path_chk.sv
module hostport_tx_path_chk #(
   parameter int ADDR_W    = 3,
   parameter int LAST_ADDR = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              core_wr,
   input logic              host_rd,
   input logic [ADDR_W-1:0] host_addr,
   input logic              rx_full,
   input logic              tx_empty,
   input logic              rx_req,
   input logic              tx_ie,
   input logic              host_req_n,
   input logic              core_irq
);
   AST_WR_CLEARS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      core_wr |=> !tx_empty); // R2

   AST_XFER_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_full && !tx_empty && !core_wr) |=> (rx_full && tx_empty)); // R3

   AST_LAST_READ_FREES: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_full && host_rd && host_addr == ADDR_W'(LAST_ADDR)) |=> !rx_full); // R5

   AST_EARLY_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_full && host_addr != ADDR_W'(LAST_ADDR)) |=> rx_full); // R5

   AST_FULL_HOLDS_EMPTY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_full && !tx_empty) |=> !tx_empty); // R11

   AST_REQ_PIN: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_req && rx_full) |-> !host_req_n); // R6

   AST_REQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_full |-> host_req_n); // R6

   AST_IRQ_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_ie && tx_empty) |-> core_irq); // R7

   AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_empty |-> !core_irq); // R7
endmodule

bind hostport_tx_path hostport_tx_path_chk #(
   .ADDR_W    (ADDR_W),
   .LAST_ADDR (WIN_BASE + WORD_W / BYTE_W - 1)
) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .core_wr    (core_wr),
   .host_rd    (host_rd),
   .host_addr  (host_addr),
   .rx_full    (rx_full),
   .tx_empty   (tx_empty),
   .rx_req     (hctl.rx_req),
   .tx_ie      (cctl.tx_ie),
   .host_req_n (host_req_n),
   .core_irq   (core_irq)
);

// File: tb/test_hostport_tx_path.sv
module test_hostport_tx_path;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        core_wr = 1'b0;
   logic [23:0] core_wdata = '0;
   logic        core_ctrl_wr = 1'b0;
   logic [4:0]  core_ctrl_wdata = '0;
   logic [4:0]  core_ctrl_rd;
   logic [7:0]  core_status;
   logic        core_irq;
   logic [7:0]  core_irq_vector;
   logic [2:0]  host_addr = '0;
   logic        host_rd = 1'b0;
   logic        host_wr = 1'b0;
   logic [7:0]  host_wdata = '0;
   logic [7:0]  host_rdata;
   logic        host_req_n;

   int n_cmp = 0;
   int n_bad = 0;
   int n_cyc = 0;

   always #2.5 clk = ~clk;

   hostport_tx_path i_hostport_tx_path (
      .clk             (clk),
      .rst_n           (rst_n),
      .core_wr         (core_wr),
      .core_wdata      (core_wdata),
      .core_ctrl_wr    (core_ctrl_wr),
      .core_ctrl_wdata (core_ctrl_wdata),
      .core_ctrl_rd    (core_ctrl_rd),
      .core_status     (core_status),
      .core_irq        (core_irq),
      .core_irq_vector (core_irq_vector),
      .host_addr       (host_addr),
      .host_rd         (host_rd),
      .host_wr         (host_wr),
      .host_wdata      (host_wdata),
      .host_rdata      (host_rdata),
      .host_req_n      (host_req_n)
   );

   // behavioural reference
   bit          m_htde, m_rxf;
   bit [23:0]   m_hold, m_word;
   bit [4:0]    m_ctrl;
   bit [7:0]    m_hcr;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_htde = 1; m_rxf = 0; m_hold = 0; m_word = 0; m_ctrl = 0; m_hcr = 0;
      end else begin
         bit go;
         bit n_rxf, n_htde;
         go     = !m_rxf && !m_htde;
         n_rxf  = m_rxf;
         n_htde = m_htde;
         if (go) begin
            m_word = m_hold; n_rxf = 1; n_htde = 1;
         end else if (host_rd && host_addr == 3'd7) begin
            n_rxf = 0;
         end
         if (core_wr) begin
            m_hold = core_wdata; n_htde = 0;
         end
         if (core_ctrl_wr) m_ctrl = core_ctrl_wdata;
         if (host_wr && host_addr == 3'd0) m_hcr = host_wdata & 8'h1B;
         m_rxf = n_rxf; m_htde = n_htde;
      end
   end

   function automatic bit [7:0] exp_rdata(input bit [2:0] a);
      bit req;
      req = m_hcr[0] && m_rxf;
      case (a)
         3'd0:    return m_hcr;
         3'd2:    return {req, 2'b00, m_ctrl[4:3], 1'b1, 1'b1, m_rxf};
         3'd5:    return m_word[23:16];
         3'd6:    return m_word[15:8];
         3'd7:    return m_word[7:0];
         default: return 8'h00;
      endcase
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      if (!rst_n) return;
      check("R6 host_req_n", 32'(host_req_n), 32'(!(m_hcr[0] && m_rxf)));
      check("R7 core_irq", 32'(core_irq), 32'(m_ctrl[1] && m_htde));
      check("R1 R9 core_status", 32'(core_status), 32'({3'b000, m_hcr[4:3], 1'b0, m_htde, 1'b0}));
      check("R9 core_ctrl_rd", 32'(core_ctrl_rd), 32'(m_ctrl));
      check("R4 R8 R9 host_rdata", 32'(host_rdata), 32'(exp_rdata(host_addr)));
   endtask

   task automatic cyc(input bit wr, input bit [23:0] wd, input bit cw, input bit [4:0] cd,
                      input bit hw, input bit hr, input bit [2:0] ha, input bit [7:0] hd);
      @(negedge clk);
      compare_all();
      core_wr = wr; core_wdata = wd; core_ctrl_wr = cw; core_ctrl_wdata = cd;
      host_wr = hw; host_rd = hr; host_addr = ha; host_wdata = hd;
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   always @(posedge clk) begin
      n_cyc++;
      if (n_cyc > 150000) begin
         n_bad++;
         $display("FAIL watchdog actual=%0d expected<=150000", n_cyc);
         summary();
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 / R1 reset state
      check("R10 core_status", 32'(core_status), 32'h02);
      check("R10 host_req_n", 32'(host_req_n), 32'h1);
      check("R10 core_irq", 32'(core_irq), 32'h0);
      check("R10 core_ctrl_rd", 32'(core_ctrl_rd), 32'h0);
      check("R7 vector", 32'(core_irq_vector), 32'h32);

      cyc(0, 0, 1, 5'b01010, 0, 0, 0, 0);            // tx ie + flag0
      cyc(0, 0, 0, 0, 1, 0, 0, 8'h11);               // rx req + host flag1
      cyc(1, 24'hA1B2C3, 0, 0, 0, 0, 0, 0);
      cyc(0, 0, 0, 0, 0, 0, 2, 0);
      check("R2 empty cleared", 32'(core_status[1]), 32'h0);
      cyc(0, 0, 0, 0, 0, 1, 5, 0);
      check("R3 empty set", 32'(core_status[1]), 32'h1);
      check("R3 request", 32'(host_req_n), 32'h0);
      #1 check("R4 high byte", 32'(host_rdata), 32'hA1);
      cyc(0, 0, 0, 0, 0, 1, 6, 0);
      check("R5 kept after addr5", 32'(host_req_n), 32'h0);
      #1 check("R4 mid byte", 32'(host_rdata), 32'hB2);
      cyc(0, 0, 0, 0, 0, 1, 7, 0);
      check("R5 kept after addr6", 32'(host_req_n), 32'h0);
      #1 check("R4 low byte", 32'(host_rdata), 32'hC3);
      cyc(1, 24'h445566, 0, 0, 0, 0, 0, 0);
      check("R5 cleared by addr7", 32'(host_req_n), 32'h1);
      cyc(0, 0, 0, 0, 0, 0, 0, 0);
      cyc(1, 24'h778899, 0, 0, 0, 0, 5, 0);
      cyc(0, 0, 0, 0, 0, 0, 5, 0);
      check("R11 held while full", 32'(core_status[1]), 32'h0);
      #1 check("R11 old word kept", 32'(host_rdata), 32'h44);
      cyc(0, 0, 0, 0, 0, 0, 5, 0);
      #1 check("R11 old word kept", 32'(host_rdata), 32'h44);
      cyc(0, 0, 0, 0, 0, 1, 7, 0);
      cyc(0, 0, 0, 0, 0, 0, 5, 0);
      cyc(0, 0, 0, 0, 0, 0, 5, 0);
      #1 check("R11 new word moved", 32'(host_rdata), 32'h77);
      check("R11 request", 32'(host_req_n), 32'h0);
      cyc(0, 0, 0, 0, 1, 0, 0, 8'h00);
      cyc(0, 0, 0, 0, 0, 0, 2, 0);
      check("R6 masked request", 32'(host_req_n), 32'h1);
      check("R7 irq on", 32'(core_irq), 32'h1);
      cyc(0, 0, 1, 5'b00000, 0, 0, 2, 0);
      cyc(0, 0, 0, 0, 0, 0, 2, 0);
      check("R7 irq masked", 32'(core_irq), 32'h0);

      for (int i = 0; i < 4000; i++) begin
         int op;
         bit [2:0] a;
         op = int'($urandom_range(0, 9));
         a  = 3'($urandom_range(0, 7));
         case (op)
            0, 1: cyc(1, 24'($urandom), 0, 0, 0, 0, a, 0);
            2:    cyc(0, 0, 1, 5'($urandom), 0, 0, a, 0);
            3:    cyc(0, 0, 0, 0, 1, 0, 0, 8'($urandom));
            4, 5: cyc(0, 0, 0, 0, 0, 1, 3'd7, 0);
            6:    cyc(1, 24'($urandom), 0, 0, 0, 1, a, 0);
            default: cyc(0, 0, 0, 0, 0, 1, a, 0);
         endcase
      end
      cyc(0, 0, 0, 0, 0, 0, 0, 0);
      summary();
   end
endmodule